// File: doc/BRIEF.md
# Loop Capture and Replay Sequencer

This block sits between a host processor and a vector datapath. It lets the datapath run a loop body without the host after the host has issued that body once. The host opens a loop with a start command that carries the total iteration count. The host then streams the body one instruction at a time. The sequencer passes each instruction on to the datapath and also writes it into a small loop buffer. When the host marks the end of the body, the sequencer pulses a suspend signal, so the host thread can park while the host runs other work.

From then on, the sequencer reads the buffer and reissues the body on its own, one instruction per cycle, back to back. It stops when the iteration counter runs out. The recorded first pass counts as one iteration. At that point it sends a single-cycle wake pulse so the host can resume the parked thread. The next cycle it is idle and ready for a new start command. A body longer than the buffer aborts the capture and raises a sticky overflow flag.

Top module: `loop_replay_seq`

## Requirements
- R1: A start pulse while idle loads the iteration count, clears the overflow flag and opens capture. A start pulse at any other time has no effect on the loop in progress.
- R2: During capture, each host instruction is presented on the datapath port exactly once, one cycle after the host offers it, in order, and is stored in the loop buffer.
- R3: The end-of-body marker closes capture and raises `suspend_o` for exactly one cycle. An instruction offered in the same cycle as the marker is the last one of the body.
- R4: After capture, the stored body is reissued in order, with one instruction per cycle and no gaps, until the total number of iterations equals the loaded count. The first pass is included in that total. A count of 0 or 1 means no replay.
- R5: `wake_o` is high for exactly one cycle. In that cycle the datapath port carries the final instruction of the final iteration. A start pulse in the following cycle is accepted.
- R6: With a buffer of DEPTH entries, offering instruction DEPTH+1 in one capture sets `overflow_o`. That instruction is not forwarded, the capture is abandoned, and neither suspend nor wake is raised.
- R7: Host instructions and end markers outside capture are ignored. They produce no datapath output and no suspend or wake pulse.
- R8: An end marker with an empty body completes at once: suspend and wake are raised in the same cycle and no instruction is issued.
- R9: After reset, `dp_valid_o`, `dp_insn_o`, `suspend_o`, `wake_o` and `overflow_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start-of-loop command |
| count_i | input | CNT_W | Total iteration count, sampled with start_i |
| host_valid_i | input | 1 | Host instruction offered this cycle |
| host_insn_i | input | INSN_W | Host instruction word |
| host_end_i | input | 1 | End-of-body marker |
| dp_valid_o | output | 1 | Instruction valid toward the datapath |
| dp_insn_o | output | INSN_W | Instruction word toward the datapath |
| suspend_o | output | 1 | One-cycle pulse: park the host thread |
| wake_o | output | 1 | One-cycle pulse: loop complete, resume the host thread |
| overflow_o | output | 1 | Sticky: the body did not fit in the loop buffer |

## Verification
The bench sweeps every body length from one entry up to a completely full buffer, against counts 0 through 4. This covers the off-by-one in how the counter treats the first pass: a design that forgot that pass would issue one body too many, and one that replayed for a count of 0 or 1 would emit extra instructions. Each run compares the full output stream against the arithmetic expectation. A wrap bug in the read pointer would show up as a mis-ordered or skipped instruction, and a read latency that was not aligned would show up as a wake pulse that is not on the final instruction. Separate runs offer one instruction past capacity (a design that missed the limit would forward it or suspend), inject host traffic and start pulses during replay (a leaky design would lengthen or restart the stream), and close an empty body (a naive design would hang in replay).

// File: rtl/loop_seq_pkg.sv
package loop_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RECORD = 2'd1,
    ST_REPLAY = 2'd2,
    ST_DONE   = 2'd3
  } seq_state_e;

endpackage

// File: rtl/loop_seq_buf.sv
module loop_seq_buf #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] store [DEPTH];

  // Synchronous write and registered read, so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end

  // Capture and replay never overlap, so the port never sees both at once
  AST_NO_RW_COLLIDE: assert property (@(posedge clk) disable iff (rst)
    !(we && re)); // R7

endmodule

// File: rtl/loop_seq_cnt.sv
module loop_seq_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             at_last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - CNT_W'(1);
  end

  // A count of 0 behaves like 1: the current iteration is the last one
  assign at_last = (cnt_q <= CNT_W'(1));

  AST_DEC_ABOVE_ONE: assert property (@(posedge clk) disable iff (rst)
    dec |-> (cnt_q > CNT_W'(1))); // R4
  AST_LOAD_DEC_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(load && dec)); // R1

endmodule

// File: rtl/loop_replay_seq.sv
module loop_replay_seq
  import loop_seq_pkg::*;
#(
  parameter int INSN_W = 16,
  parameter int DEPTH  = 32,
  parameter int CNT_W  = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              host_valid_i,
  input  logic [INSN_W-1:0] host_insn_i,
  input  logic              host_end_i,
  output logic              dp_valid_o,
  output logic [INSN_W-1:0] dp_insn_o,
  output logic              suspend_o,
  output logic              wake_o,
  output logic              overflow_o
);

  seq_state_e state_q;

  logic [PTR_W-1:0]  wr_ptr_q;
  logic [PTR_W-1:0]  rd_ptr_q;
  logic [PTR_W-1:0]  len_q;
  logic              fwd_vld_q;
  logic [INSN_W-1:0] fwd_q;
  logic              rep_vld_q;
  logic              suspend_q;
  logic              wake_q;
  logic              ovf_q;
  logic [INSN_W-1:0] rd_data;

  logic             full;
  logic             acc_insn;
  logic             ovf_hit;
  logic             end_hit;
  logic [PTR_W-1:0] body_len;
  logic             last_rd;
  logic             iter_end;
  logic             at_last;
  logic             cnt_load;
  logic             cnt_dec;

  // ---------------- decode ----------------
  assign full     = (wr_ptr_q == PTR_W'(DEPTH));
  assign acc_insn = (state_q == ST_RECORD) && host_valid_i && !full;
  assign ovf_hit  = (state_q == ST_RECORD) && host_valid_i && full;
  assign end_hit  = (state_q == ST_RECORD) && host_end_i && !ovf_hit;
  assign body_len = wr_ptr_q + PTR_W'(acc_insn);
  assign last_rd  = ((rd_ptr_q + PTR_W'(1)) == len_q);
  assign iter_end = (state_q == ST_REPLAY) && last_rd;

  assign cnt_load = (state_q == ST_IDLE) && start_i;
  assign cnt_dec  = !at_last &&
                    ((end_hit && (body_len != '0)) || iter_end);

  // ---------------- storage and iteration count ----------------
  loop_seq_buf #(
    .DATA_W (INSN_W),
    .DEPTH  (DEPTH)
  ) u_buf (
    .clk   (clk),
    .rst   (rst),
    .we    (acc_insn),
    .waddr (wr_ptr_q[ADDR_W-1:0]),
    .wdata (host_insn_i),
    .re    (state_q == ST_REPLAY),
    .raddr (rd_ptr_q[ADDR_W-1:0]),
    .rdata (rd_data)
  );

  loop_seq_cnt #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (count_i),
    .dec      (cnt_dec),
    .at_last  (at_last)
  );

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      len_q     <= '0;
      fwd_vld_q <= 1'b0;
      fwd_q     <= '0;
      rep_vld_q <= 1'b0;
      suspend_q <= 1'b0;
      wake_q    <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      fwd_vld_q <= 1'b0;
      rep_vld_q <= 1'b0;
      suspend_q <= 1'b0;
      wake_q    <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q  <= ST_RECORD;
            wr_ptr_q <= '0;
            ovf_q    <= 1'b0;
          end
        end
        ST_RECORD: begin
          if (ovf_hit) begin
            ovf_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            if (acc_insn) begin
              wr_ptr_q  <= wr_ptr_q + PTR_W'(1);
              fwd_vld_q <= 1'b1;
              fwd_q     <= host_insn_i;
            end
            if (end_hit) begin
              suspend_q <= 1'b1;
              len_q     <= body_len;
              rd_ptr_q  <= '0;
              if (at_last || (body_len == '0)) begin
                state_q <= ST_DONE;
                wake_q  <= 1'b1;
              end else begin
                state_q <= ST_REPLAY;
              end
            end
          end
        end
        ST_REPLAY: begin
          rep_vld_q <= 1'b1;
          rd_ptr_q  <= last_rd ? '0 : rd_ptr_q + PTR_W'(1);
          if (iter_end && at_last) begin
            state_q <= ST_DONE;
            wake_q  <= 1'b1;
          end
        end
        ST_DONE: begin
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dp_valid_o = fwd_vld_q | rep_vld_q;
  assign dp_insn_o  = rep_vld_q ? rd_data : fwd_q;
  assign suspend_o  = suspend_q;
  assign wake_o     = wake_q;
  assign overflow_o = ovf_q;

  // ---------------- assertions ----------------
  AST_DP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(fwd_vld_q && rep_vld_q)); // R2
  AST_SUSPEND_PULSE: assert property (@(posedge clk) disable iff (rst)
    suspend_q |=> !suspend_q); // R3
  AST_RD_IN_BODY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_REPLAY) |-> (rd_ptr_q < len_q)); // R4
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (rst)
    wake_q |=> !wake_q); // R5
  AST_WAKE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    wake_q |=> (state_q == ST_IDLE)); // R5
  AST_OVF_NO_FORWARD: assert property (@(posedge clk) disable iff (rst)
    ovf_hit |=> (!fwd_vld_q && ovf_q && !suspend_q && (state_q == ST_IDLE))); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_REPLAY) && start_i) |=> (state_q != ST_RECORD)); // R1
  AST_HOST_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ((state_q != ST_RECORD) && host_valid_i) |=> !fwd_vld_q); // R7

endmodule

// File: tb/test_loop_replay_seq.sv
`timescale 1ns/1ps
module test_loop_replay_seq;

  localparam int INSN_W = 16;
  localparam int DEPTH  = 8;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [CNT_W-1:0]  count_i = '0;
  logic              host_valid_i = 1'b0;
  logic [INSN_W-1:0] host_insn_i = '0;
  logic              host_end_i = 1'b0;
  logic              dp_valid_o;
  logic [INSN_W-1:0] dp_insn_o;
  logic              suspend_o;
  logic              wake_o;
  logic              overflow_o;

  always #2.5 clk = ~clk;

  loop_replay_seq #(
    .INSN_W (INSN_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
  ) i_loop_replay_seq (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .count_i      (count_i),
    .host_valid_i (host_valid_i),
    .host_insn_i  (host_insn_i),
    .host_end_i   (host_end_i),
    .dp_valid_o   (dp_valid_o),
    .dp_insn_o    (dp_insn_o),
    .suspend_o    (suspend_o),
    .wake_o       (wake_o),
    .overflow_o   (overflow_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // output monitor, sampled 1 ns after each rising edge
  logic [INSN_W-1:0] log_q [256];
  int  n_out, n_susp, n_wake;
  bit  wake_wide, prev_wake, wake_dp;
  logic [INSN_W-1:0] wake_insn;

  always @(posedge clk) begin
    #1;
    if (dp_valid_o) begin
      if (n_out < 256) log_q[n_out] = dp_insn_o;
      n_out++;
    end
    if (suspend_o) n_susp++;
    if (wake_o) begin
      n_wake++;
      wake_dp   = dp_valid_o;
      wake_insn = dp_insn_o;
      if (prev_wake) wake_wide = 1'b1;
    end
    prev_wake = wake_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    n_out = 0; n_susp = 0; n_wake = 0;
    wake_wide = 1'b0; wake_dp = 1'b0; wake_insn = '0;
  endtask

  // one full loop: start, capture len instructions, wait for completion
  task automatic run_loop(input int len, input int cnt, input int base,
                          input bit inject);
    int eff, exp_n, bad;
    clear_mon();
    @(negedge clk);
    start_i = 1'b1; count_i = CNT_W'(cnt);
    @(negedge clk);
    start_i = 1'b0;
    if (len == 0) begin
      host_end_i = 1'b1;
      @(negedge clk);
    end
    for (int i = 0; i < len; i++) begin
      host_valid_i = 1'b1;
      host_insn_i  = INSN_W'(base + i);
      host_end_i   = (i == len - 1);
      @(negedge clk);
    end
    host_valid_i = 1'b0; host_end_i = 1'b0;
    for (int w = 0; w < 400; w++) begin
      if (n_wake > 0) break;
      if (inject && w < 3) begin
        // R7 / R1: host traffic and a start pulse during replay
        host_valid_i = 1'b1; host_insn_i = 16'hDEAD; host_end_i = 1'b1;
        start_i = 1'b1; count_i = 8'd1;
      end else begin
        host_valid_i = 1'b0; host_end_i = 1'b0; start_i = 1'b0;
      end
      @(negedge clk);
    end
    host_valid_i = 1'b0; host_end_i = 1'b0; start_i = 1'b0;
    repeat (3) @(negedge clk);

    eff   = (cnt <= 1) ? 1 : cnt;
    exp_n = len * eff;
    chk(n_out == exp_n, "R4", $sformatf("issued count len=%0d cnt=%0d", len, cnt),
        n_out, exp_n);
    bad = 0;
    for (int k = 0; k < exp_n && k < n_out; k++)
      if (log_q[k] != INSN_W'(base + (k % len))) bad++;
    chk(bad == 0, (cnt <= 1) ? "R2" : "R4",
        $sformatf("order mismatches len=%0d cnt=%0d", len, cnt), bad, 0);
    chk(n_susp == 1, "R3", "suspend pulses", n_susp, 1);
    chk(n_wake == 1 && !wake_wide, "R5", "wake pulses", n_wake, 1);
    if (len > 0)
      chk(wake_dp && wake_insn == INSN_W'(base + len - 1), "R5",
          "insn under wake", wake_insn, base + len - 1);
  endtask

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(!dp_valid_o && dp_insn_o == '0, "R9", "dp after reset", dp_valid_o, 0);
    chk(!suspend_o && !wake_o && !overflow_o, "R9", "flags after reset",
        {suspend_o, wake_o, overflow_o}, 0);

    // R7: host traffic while idle is ignored
    clear_mon();
    host_valid_i = 1'b1; host_insn_i = 16'h1234; host_end_i = 1'b1;
    repeat (4) @(negedge clk);
    host_valid_i = 1'b0; host_end_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(n_out == 0 && n_susp == 0 && n_wake == 0, "R7", "idle host traffic",
        n_out + n_susp + n_wake, 0);

    // R2/R4/R5 sweep: body length 1..DEPTH, counts 0..4
    for (int len = 1; len <= DEPTH; len++)
      for (int cnt = 0; cnt <= 4; cnt++)
        run_loop(len, cnt, 256 * len + 16 * cnt, 1'b0);

    // R1/R7: start pulse and host traffic during replay are ignored
    run_loop(3, 4, 16'h7000, 1'b1);

    // R8: empty body
    run_loop(0, 3, 0, 1'b0);
    chk(n_out == 0, "R8", "empty body issued", n_out, 0);

    // R6: one instruction past capacity
    clear_mon();
    @(negedge clk);
    start_i = 1'b1; count_i = 8'd3;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i <= DEPTH; i++) begin
      host_valid_i = 1'b1; host_insn_i = INSN_W'(16'h5000 + i);
      @(negedge clk);
    end
    host_valid_i = 1'b0;
    chk(overflow_o == 1'b1, "R6", "overflow flag", overflow_o, 1);
    @(negedge clk);
    chk(n_out == DEPTH, "R6", "forwarded before overflow", n_out, DEPTH);
    // R7: end marker after abort is ignored
    host_end_i = 1'b1;
    @(negedge clk);
    host_end_i = 1'b0;
    repeat (20) @(negedge clk);
    chk(n_susp == 0 && n_wake == 0, "R6", "pulses after overflow",
        n_susp + n_wake, 0);
    chk(n_out == DEPTH, "R7", "output after abort", n_out, DEPTH);
    chk(overflow_o == 1'b1, "R6", "overflow sticky", overflow_o, 1);
    // R1: next start clears the flag
    start_i = 1'b1; count_i = 8'd1;
    @(negedge clk);
    start_i = 1'b0;
    chk(overflow_o == 1'b0, "R1", "overflow cleared by start", overflow_o, 0);
    clear_mon();
    host_valid_i = 1'b1; host_insn_i = 16'h0042; host_end_i = 1'b1;
    @(negedge clk);
    host_valid_i = 1'b0; host_end_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(n_wake == 1 && n_out == 1 && log_q[0] == 16'h0042, "R1",
        "loop after overflow", n_out, 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule